// File: doc/BRIEF.md
# Three-Stage Escalating Watchdog Timer

This block is a single-channel watchdog timer on a plain 64-bit register bus. Once software arms it, the timer counts down. Each full period that passes without a poke advances an escalation stage. The first expiry raises a CPU interrupt that acts as an early warning. The second expiry can signal a management processor. The third expiry requests a system reset, and that request stays asserted until the block itself is reset.

A free-running prescaler divides the input clock, by 1024 by default, and the countdown steps once per prescaler tick. The reload length is 16 bits wide. It fills the upper part of a wider down counter whose low bits load as zero, so one period lasts `(length << LOW_W) + 1` ticks: the counter reaches zero, and the expiry happens on the tick that finds it at zero. Software keeps the system alive by writing the poke register. A poke reloads the counter and returns escalation to the first stage.

Register offsets: control at 0x00, interrupt pending at 0x08, enable-set at 0x10, enable-clear at 0x18, poke at 0x20. The pending and enable registers each use only bit `IRQ_BIT`. Reads return data one cycle after `rd_en`, and `rd_data` holds its value between reads.

Top module: `wdt_three_stage`

## Requirements
- R1: After reset all outputs are low, the control word reads zero, the mode is stopped, and the counter does not run.
- R2: While the mode is non-zero the count drops by one on every prescaler tick (every `DIV` clocks), and at no other time.
- R3: A write to the control word, or a poke, loads the counter with the 16-bit length in its upper bits and zero in its lower `LOW_W` bits.
- R4: Mode 0 (control bits [1:0] = 0) freezes the count, clears the escalation stage, and raises no event, so `rst_req` stays low.
- R5: In mode 1 every expiry sets the pending bit, and the block never drives the management interrupt or the reset request.
- R6: In mode 2 the first expiry sets the pending bit and the second drives `irq_mgmt`; `rst_req` never rises in this mode.
- R7: In mode 3 the third consecutive expiry without a poke raises `rst_req`, which holds through pokes and mode writes until `rst_n` is asserted.
- R8: Control bit 2 enables the management interrupt. When it is 0 the second expiry only advances the stage, and a mode 3 reset still follows on the third expiry.
- R9: A write to the poke register with bit 0 = 1 reloads the counter, returns to the first stage and clears `irq_mgmt`. A poke with bit 0 = 0 has no effect. A poke beats an expiry in the same cycle.
- R10: Writing 1 to bit `IRQ_BIT` of the pending register clears the pending bit. If an expiry sets the bit in the same cycle, the set wins.
- R11: Writing 1 to bit `IRQ_BIT` of the enable-set register enables the interrupt, and writing 1 to that bit of the enable-clear register disables it. `irq_cpu` is high exactly when the bit is both pending and enabled.
- R12: A control read returns the mode in [1:0], the management enable in [2], the length in [19:4] and the live count in [20 +: 16+LOW_W]. Any read takes one cycle, and `rd_data` is unchanged when no read is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of register |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Read data, valid the cycle after `rd_en` |
| irq_cpu | output | 1 | CPU interrupt (pending AND enabled) |
| irq_mgmt | output | 1 | Management-processor interrupt |
| rst_req | output | 1 | Sticky reset request |

## Verification
Two pairs of events can land on the same clock edge. A poke can arrive on the edge where the counter would expire, and a pending-clear write can arrive on the edge where an expiry sets the pending bit. The bench finds those edges from its own timing model: it waits until the modelled counter is at zero with a tick due next, then issues the write on that edge. It then checks two things. First, that the poke suppresses the expiry, so no pending bit appears and the stage stays at the first. Second, that the pending bit survives the clear, so `irq_cpu` stays high. The per-clock comparison against the behavioural model covers every other cycle of those runs.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int unsigned RELOAD_W = 16;
   localparam int unsigned BUS_W    = 64;
   localparam int unsigned ADDR_W   = 8;
   localparam int unsigned F_MGMT   = 2;
   localparam int unsigned F_LEN    = 4;
   localparam int unsigned F_CNT    = 20;

   localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h00;
   localparam logic [ADDR_W-1:0] OFS_PEND    = 8'h08;
   localparam logic [ADDR_W-1:0] OFS_ENA_SET = 8'h10;
   localparam logic [ADDR_W-1:0] OFS_ENA_CLR = 8'h18;
   localparam logic [ADDR_W-1:0] OFS_POKE    = 8'h20;

   typedef enum logic [1:0] {
      MODE_STOP     = 2'd0,
      MODE_IRQ      = 2'd1,
      MODE_IRQ_MGMT = 2'd2,
      MODE_FULL     = 2'd3
   } wdt_mode_e;

   typedef enum logic [1:0] {
      STG_FIRST  = 2'd0,
      STG_SECOND = 2'd1,
      STG_THIRD  = 2'd2
   } wdt_stage_e;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
   parameter int unsigned DIV = 1024
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV == 0) begin : g_bad_div
         $error("wdt_prescale: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_pass
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign tick = 1'b1;
      end else begin : g_count
         localparam int unsigned PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] div_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              div_q <= '0;
            else if (div_q == LAST)  div_q <= '0;
            else                     div_q <= div_q + 1'b1;
         end

         assign tick = (div_q == LAST);

         a_r2_prescale_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> (div_q == '0));
      end
   endgenerate
endmodule

// File: rtl/wdt_stage_ctl.sv
module wdt_stage_ctl
   import wdt_pkg::*;
#(
   parameter int unsigned LOW_W = 8,
   localparam int unsigned CNT_W = RELOAD_W + LOW_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                reload,
   input  logic [RELOAD_W-1:0] ld_len,
   input  wdt_mode_e           mode,
   input  logic                mgmt_en,
   output logic [CNT_W-1:0]    count,
   output logic                first_exp,
   output logic                irq_mgmt,
   output logic                rst_req
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] full_val;
   wdt_stage_e       stage_q;
   logic             mgmt_q;
   logic             rst_q;
   logic             expire;

   generate
      if (LOW_W == 0) begin : g_no_low
         assign full_val = ld_len;
      end else begin : g_low
         assign full_val = {ld_len, {LOW_W{1'b0}}};
      end
   endgenerate

   assign expire    = tick && (mode != MODE_STOP) && !reload && (cnt_q == '0);
   assign first_exp = expire && ((mode == MODE_IRQ) || (stage_q == STG_FIRST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         stage_q <= STG_FIRST;
         mgmt_q  <= 1'b0;
         rst_q   <= 1'b0;
      end else if (reload) begin
         cnt_q   <= full_val;
         stage_q <= STG_FIRST;
         mgmt_q  <= 1'b0;
      end else if (tick && (mode != MODE_STOP)) begin
         if (cnt_q == '0) begin
            cnt_q <= full_val;
            if (mode != MODE_IRQ) begin
               unique case (stage_q)
                  STG_FIRST:  stage_q <= STG_SECOND;
                  STG_SECOND: begin
                     stage_q <= STG_THIRD;
                     if (mgmt_en) mgmt_q <= 1'b1;
                  end
                  default: if (mode == MODE_FULL) rst_q <= 1'b1;
               endcase
            end
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign count    = cnt_q;
   assign irq_mgmt = mgmt_q;
   assign rst_req  = rst_q;

   a_r2_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload && !tick) |=> $stable(cnt_q));
   a_r3_reload_len: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (cnt_q[CNT_W-1 -: RELOAD_W] == $past(ld_len)));
   a_r4_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == MODE_STOP) && !reload) |=> $stable(cnt_q) && $stable(stage_q));
   a_r6_no_reset_low_modes: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode != MODE_FULL) && !rst_q) |=> !rst_q);
   a_r7_reset_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |=> rst_q);
   a_r8_mgmt_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!mgmt_en && !mgmt_q) |=> !mgmt_q);
   a_r9_poke_restart: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (stage_q == STG_FIRST) && !mgmt_q);
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
   import wdt_pkg::*;
#(
   parameter int unsigned LOW_W   = 8,
   parameter int unsigned IRQ_BIT = 0,
   localparam int unsigned CNT_W  = RELOAD_W + LOW_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [BUS_W-1:0]    wr_data,
   input  logic [CNT_W-1:0]    count,
   input  logic                set_pend,
   output logic [BUS_W-1:0]    rd_data,
   output logic                reload,
   output logic [RELOAD_W-1:0] ld_len,
   output wdt_mode_e           mode,
   output logic                mgmt_en,
   output logic                irq_cpu
);
   wdt_mode_e           mode_q;
   logic                mgmt_en_q;
   logic [RELOAD_W-1:0] len_q;
   logic                pend_q;
   logic                ena_q;
   logic [BUS_W-1:0]    rd_q;
   logic [BUS_W-1:0]    rd_next;
   logic                ctrl_wr, poke_wr, pend_clr, ena_set, ena_clr;
   logic                unused_wr_bits;

   assign ctrl_wr  = wr_en && (addr == OFS_CTRL);
   assign poke_wr  = wr_en && (addr == OFS_POKE) && wr_data[0];
   assign pend_clr = wr_en && (addr == OFS_PEND) && wr_data[IRQ_BIT];
   assign ena_set  = wr_en && (addr == OFS_ENA_SET) && wr_data[IRQ_BIT];
   assign ena_clr  = wr_en && (addr == OFS_ENA_CLR) && wr_data[IRQ_BIT];
   assign unused_wr_bits = ^wr_data;

   assign reload = ctrl_wr || poke_wr;
   assign ld_len = ctrl_wr ? wr_data[F_LEN +: RELOAD_W] : len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= MODE_STOP;
         mgmt_en_q <= 1'b0;
         len_q     <= '0;
         pend_q    <= 1'b0;
         ena_q     <= 1'b0;
         rd_q      <= '0;
      end else begin
         if (ctrl_wr) begin
            mode_q    <= wdt_mode_e'(wr_data[1:0]);
            mgmt_en_q <= wr_data[F_MGMT];
            len_q     <= wr_data[F_LEN +: RELOAD_W];
         end
         if (set_pend)      pend_q <= 1'b1;
         else if (pend_clr) pend_q <= 1'b0;
         if (ena_set)       ena_q <= 1'b1;
         else if (ena_clr)  ena_q <= 1'b0;
         if (rd_en)         rd_q <= rd_next;
      end
   end

   always_comb begin
      rd_next = '0;
      unique case (addr)
         OFS_CTRL: begin
            rd_next[1:0]              = mode_q;
            rd_next[F_MGMT]           = mgmt_en_q;
            rd_next[F_LEN +: RELOAD_W] = len_q;
            rd_next[F_CNT +: CNT_W]   = count;
         end
         OFS_PEND:                rd_next[IRQ_BIT] = pend_q;
         OFS_ENA_SET, OFS_ENA_CLR: rd_next[IRQ_BIT] = ena_q;
         default: ;
      endcase
   end

   assign rd_data = rd_q;
   assign mode    = mode_q;
   assign mgmt_en = mgmt_en_q;
   assign irq_cpu = pend_q && ena_q;

   a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_pend |=> irq_cpu || !ena_q);
   a_r11_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
      ena_set |=> ena_q);
   a_r11_enable_clr: assert property (@(posedge clk) disable iff (!rst_n)
      ena_clr |=> !ena_q);
   a_r12_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/wdt_three_stage.sv
module wdt_three_stage
   import wdt_pkg::*;
#(
   parameter int unsigned DIV     = 1024,
   parameter int unsigned LOW_W   = 8,
   parameter int unsigned IRQ_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wr_data,
   output logic [BUS_W-1:0]  rd_data,
   output logic              irq_cpu,
   output logic              irq_mgmt,
   output logic              rst_req
);
   localparam int unsigned CNT_W = RELOAD_W + LOW_W;

   generate
      if (F_CNT + CNT_W > BUS_W) begin : g_bad_width
         $error("wdt_three_stage: count field does not fit the bus word");
      end
      if (IRQ_BIT >= BUS_W) begin : g_bad_bit
         $error("wdt_three_stage: IRQ_BIT outside the bus word");
      end
   endgenerate

   logic                tick;
   logic                reload;
   logic [RELOAD_W-1:0] ld_len;
   wdt_mode_e           mode;
   logic                mgmt_en;
   logic [CNT_W-1:0]    count;
   logic                first_exp;

   wdt_prescale #(.DIV(DIV)) i_prescale (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   wdt_regfile #(.LOW_W(LOW_W), .IRQ_BIT(IRQ_BIT)) i_regfile (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .addr    (addr),
      .wr_data (wr_data),
      .count   (count),
      .set_pend(first_exp),
      .rd_data (rd_data),
      .reload  (reload),
      .ld_len  (ld_len),
      .mode    (mode),
      .mgmt_en (mgmt_en),
      .irq_cpu (irq_cpu)
   );

   wdt_stage_ctl #(.LOW_W(LOW_W)) i_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .reload   (reload),
      .ld_len   (ld_len),
      .mode     (mode),
      .mgmt_en  (mgmt_en),
      .count    (count),
      .first_exp(first_exp),
      .irq_mgmt (irq_mgmt),
      .rst_req  (rst_req)
   );

   a_r5_no_escalation_mode1: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == MODE_IRQ) && !irq_mgmt && !rst_req) |=> !irq_mgmt && !rst_req);
endmodule

// File: tb/test_wdt_three_stage.sv
module test_wdt_three_stage;
   localparam int DIV = 4;
   localparam int LOW = 2;
   localparam int IB  = 3;
   localparam logic [7:0] A_CTRL = 8'h00, A_PEND = 8'h08, A_ESET = 8'h10,
                          A_ECLR = 8'h18, A_POKE = 8'h20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [63:0] wr_data = '0;
   logic [63:0] rd_data;
   logic        irq_cpu, irq_mgmt, rst_req;

   always #10 clk = ~clk;

   wdt_three_stage #(.DIV(DIV), .LOW_W(LOW), .IRQ_BIT(IB)) i_wdt_three_stage (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .irq_cpu(irq_cpu),
      .irq_mgmt(irq_mgmt), .rst_req(rst_req));

   int total = 0, bad = 0, cyc = 0;
   string cur_req = "R1";

   // behavioural reference model
   int m_presc, m_cnt, m_stage, m_mode, m_len;
   bit m_pend, m_ena, m_mgmt, m_rst, m_mgen;
   logic [63:0] m_rd;

   function automatic logic [63:0] model_read(logic [7:0] a);
      logic [63:0] v = '0;
      if (a == A_CTRL) begin
         v[1:0]   = 2'(m_mode);
         v[2]     = m_mgen;
         v[19:4]  = 16'(m_len);
         v[37:20] = 18'(m_cnt);
      end else if (a == A_PEND) v[IB] = m_pend;
      else if (a == A_ESET || a == A_ECLR) v[IB] = m_ena;
      return v;
   endfunction

   always @(posedge clk) begin
      bit tk, ctl, pk, setp;
      if (!rst_n) begin
         m_presc = 0; m_cnt = 0; m_stage = 0; m_mode = 0; m_len = 0;
         m_pend = 0; m_ena = 0; m_mgmt = 0; m_rst = 0; m_mgen = 0; m_rd = '0;
      end else begin
         tk = (m_presc == DIV - 1);
         m_presc = tk ? 0 : m_presc + 1;
         if (rd_en) m_rd = model_read(addr);
         ctl  = wr_en && addr == A_CTRL;
         pk   = wr_en && addr == A_POKE && wr_data[0];
         setp = 0;
         if (ctl) begin
            m_mode = int'(wr_data[1:0]); m_mgen = wr_data[2]; m_len = int'(wr_data[19:4]);
         end
         if (ctl || pk) begin
            m_cnt = m_len * (1 << LOW); m_stage = 0; m_mgmt = 0;
         end else if (tk && m_mode != 0) begin
            if (m_cnt == 0) begin
               m_cnt = m_len * (1 << LOW);
               if (m_mode == 1) setp = 1;
               else if (m_stage == 0) begin setp = 1; m_stage = 1; end
               else if (m_stage == 1) begin m_stage = 2; if (m_mgen) m_mgmt = 1; end
               else if (m_mode == 3) m_rst = 1;
            end else m_cnt--;
         end
         if (wr_en && addr == A_PEND && wr_data[IB]) m_pend = 0;
         if (setp) m_pend = 1;
         if (wr_en && addr == A_ESET && wr_data[IB]) m_ena = 1;
         if (wr_en && addr == A_ECLR && wr_data[IB]) m_ena = 0;
      end
   end

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk(cur_req, "irq_cpu",  64'(irq_cpu),  64'(m_pend && m_ena));
         chk(cur_req, "irq_mgmt", 64'(irq_mgmt), 64'(m_mgmt));
         chk(cur_req, "rst_req",  64'(rst_req),  64'(m_rst));
         chk(cur_req, "rd_data",  rd_data,       m_rd);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // tasks start and end 2 ns after a rising edge
   task automatic step(int n);
      repeat (n) begin @(posedge clk); #2; end
   endtask
   task automatic wr(logic [7:0] a, logic [63:0] d);
      wr_en = 1; addr = a; wr_data = d; step(1); wr_en = 0; wr_data = '0;
   endtask
   task automatic rd(logic [7:0] a, output logic [63:0] d);
      rd_en = 1; addr = a; step(1); rd_en = 0; d = rd_data;
   endtask
   function automatic logic [63:0] ctrl(int mode, bit mg, int len);
      logic [63:0] v = '0;
      v[1:0] = 2'(mode); v[2] = mg; v[19:4] = 16'(len);
      return v;
   endfunction
   task automatic wait_expiry_edge();
      while (!(m_mode != 0 && m_cnt == 0 && m_presc == DIV - 1)) step(1);
   endtask

   initial begin
      logic [63:0] d, d2;
      step(3);
      rst_n = 1; step(1);
      cur_req = "R1";
      chk("R1", "irq_cpu", 64'(irq_cpu), 0);
      chk("R1", "rst_req", 64'(rst_req), 0);
      rd(A_CTRL, d); chk("R1", "ctrl", d, 0);
      step(20); rd(A_CTRL, d); chk("R1", "ctrl idle", d, 0);

      cur_req = "R11";
      wr(A_ESET, 64'(1) << IB);
      rd(A_ESET, d); chk("R11", "enable read", d, 64'(1) << IB);

      cur_req = "R3";
      wr(A_CTRL, ctrl(1, 0, 3));
      rd(A_CTRL, d); chk("R3", "count after load", 64'(d[37:20]), 64'(3 << LOW));
      chk("R12", "mode/len fields", 64'(d[19:0]), 64'(ctrl(1, 0, 3)));

      cur_req = "R2";
      step(2 * DIV); rd(A_CTRL, d2);
      chk("R2", "count stepped", 64'(d[37:20] - d2[37:20]), 2);

      cur_req = "R5";
      step(140);
      chk("R5", "pending irq", 64'(irq_cpu), 1);
      wr(A_PEND, 64'(1) << IB);
      chk("R10", "pending cleared", 64'(irq_cpu), 0);

      cur_req = "R10";
      wait_expiry_edge();
      wr(A_PEND, 64'(1) << IB);
      chk("R10", "set beats clear", 64'(irq_cpu), 1);
      wr(A_ECLR, 64'(1) << IB);
      chk("R11", "irq masked", 64'(irq_cpu), 0);
      wr(A_ESET, 64'(1) << IB);
      chk("R11", "irq unmasked", 64'(irq_cpu), 1);
      wr(A_PEND, 64'(1) << IB);

      cur_req = "R6";
      wr(A_CTRL, ctrl(2, 1, 2));
      step(200);
      chk("R6", "mgmt raised", 64'(irq_mgmt), 1);
      chk("R6", "no reset mode2", 64'(rst_req), 0);

      cur_req = "R9";
      wr(A_POKE, 64'h0); chk("R9", "poke bit0=0 ignored", 64'(irq_mgmt), 1);
      wr(A_POKE, 64'h1); chk("R9", "poke clears mgmt", 64'(irq_mgmt), 0);
      wr(A_PEND, 64'(1) << IB);
      wait_expiry_edge();
      wr(A_POKE, 64'h1);
      chk("R9", "poke beats expiry", 64'(irq_cpu), 0);
      rd(A_CTRL, d);

      cur_req = "R8";
      wr(A_CTRL, ctrl(3, 0, 2));
      step(90);
      chk("R8", "second expiry silent", 64'(irq_mgmt), 0);
      step(40);
      chk("R8", "reset after third", 64'(rst_req), 1);

      cur_req = "R7";
      wr(A_POKE, 64'h1); wr(A_CTRL, ctrl(0, 0, 2));
      step(10);
      chk("R7", "reset sticky", 64'(rst_req), 1);
      rst_n = 0; step(2); rst_n = 1; step(1);
      chk("R7", "reset cleared by rst_n", 64'(rst_req), 0);

      cur_req = "R4";
      wr(A_ESET, 64'(1) << IB);
      wr(A_CTRL, ctrl(3, 1, 1));
      step(15);
      wr(A_CTRL, ctrl(0, 1, 1));
      rd(A_CTRL, d); step(200); rd(A_CTRL, d2);
      chk("R4", "count frozen", 64'(d2[37:20]), 64'(d[37:20]));
      chk("R4", "no reset halted", 64'(rst_req), 0);
      chk("R4", "no irq halted", 64'(irq_cpu), 0);

      step(2);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule